// File: doc/BRIEF.md
# Layered Single-Step Normalising Shifter

The block moves a data word through a stack of identical layers. A layer can move the whole word one bit position toward the most significant end, one position toward the least significant end, or leave it alone. The number of layers equals the word width, so any net move from a full width right to a full width left can be built from the layer choices. The result is captured in one output register stage.

Two modes share the stack. In explicit mode each layer takes a 2-bit step code from a control port, which makes the block a general single-step shifter. In normalise mode each layer ignores the control port and looks only at the top bit of the word that reaches it: if that bit is 0 it steps left, otherwise it passes. Leading zeros are therefore squeezed out one layer at a time and no leading-zero counter is needed. The signed net step count (left steps minus right steps) is reported so that a surrounding unit can adjust an exponent. Exponent arithmetic is left to that unit.

Top module: `nshift_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are data_out = 0, shift_cnt = 0 and zero_flag = 0.
- R2: Outputs change once per rising edge and reflect the mode_norm, data_in and ctrl_in values sampled at that same edge (one register of latency).
- R3: In normalise mode (mode_norm = 1) with a nonzero data_in, data_out equals data_in shifted left by its leading-zero count with zeros entering on the right, so data_out bit WIDTH-1 is 1.
- R4: In normalise mode with a nonzero data_in, shift_cnt equals the number of leading zeros of data_in (0 to WIDTH-1).
- R5: In normalise mode with data_in all zero, data_out is 0, shift_cnt equals WIDTH and zero_flag is 1.
- R6: In explicit mode (mode_norm = 0) layer k, k = 0 first, takes its code from ctrl_in[2k+1:2k]: 00 passes, 01 shifts left by one filling a 0 at bit 0, 10 shifts right by one filling a 0 at bit WIDTH-1, and 11 passes like 00.
- R7: In explicit mode shift_cnt is the two's-complement value of the number of layers that shifted left minus the number that shifted right.
- R8: zero_flag is 1 exactly when the registered data_out is all zero, in both modes, once reset has been released.
- R9: In normalise mode ctrl_in has no effect on data_out, shift_cnt or zero_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_norm | input | 1 | 1 selects normalise mode, 0 selects explicit mode |
| data_in | input | WIDTH (16) | Word to shift |
| ctrl_in | input | 2*WIDTH (32) | Per-layer step codes, layer k at bits [2k+1:2k] |
| data_out | output | WIDTH (16) | Registered shifted word |
| shift_cnt | output | CNT_W = clog2(WIDTH+1)+1 (6) | Registered signed net step count, left positive |
| zero_flag | output | 1 | Registered flag, result word is all zero |

## Verification
The properties take for granted that the inputs are stable around each rising edge and that every input holds a known 0 or 1, since the normalise checks relate the output to the input word sampled one edge earlier. They also assume the reset is held for at least one edge before the first result is judged; each property guards on the reset value of the previous edge. The stimulus drives all inputs on falling edges only, holds reset low for several edges, and draws random words with a random right shift applied so that every leading-zero count, including the all-zero word, is reached along with random step-code mixes that include the spare code.

// File: rtl/nshift_pkg.sv
// Shared types for the layered shifter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package nshift_pkg;

    // Per-layer step code carried on the control port in explicit mode.
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_SPARE = 2'b11
    } step_code_t;

endpackage

// File: rtl/nshift_layer.sv
// One shifter layer: moves the word by at most one bit position.
// In normalise mode it steps left when the incoming top bit is 0; in
// explicit mode it follows a 2-bit step code. BIDIR = 0 builds a
// left-only layer in which the right step code acts as a pass.
// Assumes: W >= 2.
module nshift_layer
    import nshift_pkg::*;
#(
    parameter int W     = 16,
    parameter bit BIDIR = 1'b1
) (
    input  logic [W-1:0] word_i,
    input  logic         norm_i,
    input  logic [1:0]   code_i,
    output logic [W-1:0] word_o,
    output logic         go_left,
    output logic         go_right
);

    logic       right_allow;
    step_code_t code;

    // Select whether the right step exists in this build.
    generate
        if (BIDIR) begin : g_bidir
            assign right_allow = 1'b1;
        end else begin : g_unidir
            assign right_allow = 1'b0;
        end
    endgenerate

    // Decide this layer's move from the mode, the top bit or the code.
    always_comb begin
        code     = step_code_t'(code_i);
        go_left  = 1'b0;
        go_right = 1'b0;
        if (norm_i) begin
            go_left = ~word_i[W-1];
        end else begin
            unique case (code)
                STEP_UP:   go_left  = 1'b1;
                STEP_DOWN: go_right = right_allow;
                default:   ;
            endcase
        end
    end

    // Three-way bit mux: left by one, right by one, or pass.
    always_comb begin
        word_o = word_i;
        if (go_left) begin
            word_o = {word_i[W-2:0], 1'b0};
        end else if (go_right) begin
            word_o = {1'b0, word_i[W-1:1]};
        end
    end

endmodule

// File: rtl/nshift_stack.sv
// Chain of LAYERS single-step layers plus the signed net step count.
// Layer 0 sees the input word; each later layer sees its predecessor.
// Assumes: CW is wide enough to hold -LAYERS..+LAYERS.
module nshift_stack #(
    parameter int W      = 16,
    parameter int LAYERS = 16,
    parameter bit BIDIR  = 1'b1,
    parameter int CW     = $clog2(LAYERS + 1) + 1
) (
    input  logic                   norm_i,
    input  logic [W-1:0]           word_i,
    input  logic [2*LAYERS-1:0]    ctrl_i,
    output logic [W-1:0]           word_o,
    output logic signed [CW-1:0]   count_o
);

    logic [W-1:0]      chain [LAYERS+1];
    logic [LAYERS-1:0] left_v;
    logic [LAYERS-1:0] right_v;

    assign chain[0] = word_i;

    generate
        for (genvar k = 0; k < LAYERS; k++) begin : g_layer
            nshift_layer #(
                .W     (W),
                .BIDIR (BIDIR)
            ) u_layer (
                .word_i   (chain[k]),
                .norm_i   (norm_i),
                .code_i   (ctrl_i[2*k +: 2]),
                .word_o   (chain[k+1]),
                .go_left  (left_v[k]),
                .go_right (right_v[k])
            );
        end
    endgenerate

    assign word_o = chain[LAYERS];

    // Net count: add one per left step, subtract one per right step.
    always_comb begin
        count_o = '0;
        for (int k = 0; k < LAYERS; k++) begin
            count_o = count_o + $signed({{(CW-1){1'b0}}, left_v[k]})
                              - $signed({{(CW-1){1'b0}}, right_v[k]});
        end
    end

endmodule

// File: rtl/nshift_top.sv
// Layered single-step normalising shifter with one output register.
// Holds one layer per data bit and registers word, count and zero flag.
// Assumes: WIDTH >= 2; inputs settle before each rising edge.
module nshift_top #(
    parameter int WIDTH = 16,
    parameter bit BIDIR = 1'b1,
    localparam int LAYERS = WIDTH,
    localparam int CNT_W  = $clog2(WIDTH + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_norm,
    input  logic [WIDTH-1:0]        data_in,
    input  logic [2*WIDTH-1:0]      ctrl_in,
    output logic [WIDTH-1:0]        data_out,
    output logic signed [CNT_W-1:0] shift_cnt,
    output logic                    zero_flag
);

    logic [WIDTH-1:0]        res_word;
    logic signed [CNT_W-1:0] res_cnt;

    nshift_stack #(
        .W      (WIDTH),
        .LAYERS (LAYERS),
        .BIDIR  (BIDIR),
        .CW     (CNT_W)
    ) u_stack (
        .norm_i  (mode_norm),
        .word_i  (data_in),
        .ctrl_i  (ctrl_in),
        .word_o  (res_word),
        .count_o (res_cnt)
    );

    // Capture the stack result, or clear everything under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '0;
            shift_cnt <= '0;
            zero_flag <= 1'b0;
        end else begin
            data_out  <= res_word;
            shift_cnt <= res_cnt;
            zero_flag <= (res_word == '0);
        end
    end

endmodule

// File: rtl/nshift_chk.sv
// Property checker for nshift_top, attached by bind below.
// Assumes: inputs are known and stable at each rising edge.
module nshift_chk #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mode_norm,
    input logic [WIDTH-1:0]        data_in,
    input logic [2*WIDTH-1:0]      ctrl_in,
    input logic [WIDTH-1:0]        data_out,
    input logic signed [CNT_W-1:0] shift_cnt,
    input logic                    zero_flag
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (data_out == '0 && shift_cnt == '0 && !zero_flag));

    // R8
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zero_flag == (data_out == '0)));

    // R3
    norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_norm) && !zero_flag) |-> data_out[WIDTH-1]);

    // R4
    norm_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_norm) && !zero_flag) |->
        (!shift_cnt[CNT_W-1] && data_out == ($past(data_in) << shift_cnt)));

    // R5
    norm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_norm) && $past(data_in) == '0) |->
        (zero_flag && shift_cnt == CNT_W'(WIDTH)));

    // R6
    hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_norm) && $past(ctrl_in) == '0) |->
        (data_out == $past(data_in) && shift_cnt == '0));

endmodule

bind nshift_top nshift_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_norm (mode_norm),
    .data_in   (data_in),
    .ctrl_in   (ctrl_in),
    .data_out  (data_out),
    .shift_cnt (shift_cnt),
    .zero_flag (zero_flag)
);

// File: tb/nshift_top_test.sv
// Self-checking bench for nshift_top: directed corners plus seeded
// random words and step codes, compared with a bench reference model.
module nshift_top_test;

    localparam int W  = 16;
    localparam int CW = $clog2(W + 1) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mode_norm = 1'b0;
    logic [W-1:0]         data_in = '0;
    logic [2*W-1:0]       ctrl_in = '0;
    logic [W-1:0]         data_out;
    logic signed [CW-1:0] shift_cnt;
    logic                 zero_flag;

    int total = 0;
    int bad   = 0;

    nshift_top #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_norm (mode_norm),
        .data_in   (data_in),
        .ctrl_in   (ctrl_in),
        .data_out  (data_out),
        .shift_cnt (shift_cnt),
        .zero_flag (zero_flag)
    );

    always #5 clk = ~clk;

    // Reference from the requirements: leading-zero removal or coded steps.
    function automatic void ref_model(input logic nm, input logic [W-1:0] d,
                                      input logic [2*W-1:0] c,
                                      output logic [W-1:0] r, output int n);
        r = d;
        n = 0;
        if (nm) begin
            for (int k = 0; k < W; k++) begin
                if (!r[W-1]) begin
                    r = r << 1;
                    n++;
                end
            end
        end else begin
            for (int k = 0; k < W; k++) begin
                case (c[2*k +: 2])
                    2'b01: begin r = r << 1; n++; end
                    2'b10: begin r = r >> 1; n--; end
                    default: ;
                endcase
            end
        end
    endfunction

    // Drive on a falling edge, let one rising edge capture, then compare.
    task automatic run(input logic nm, input logic [W-1:0] d,
                       input logic [2*W-1:0] c, input string tag);
        logic [W-1:0] er;
        int           en;
        mode_norm = nm;
        data_in   = d;
        ctrl_in   = c;
        ref_model(nm, d, c, er, en);
        @(posedge clk);
        #2;
        total++;
        if (data_out !== er || int'(shift_cnt) != en || zero_flag !== (er == '0)) begin
            bad++;
            $display("FAIL %s (R2) word got=%h exp=%h cnt got=%0d exp=%0d zero got=%b exp=%b",
                     tag, data_out, er, int'(shift_cnt), en, zero_flag, (er == '0));
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0419));
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (data_out !== '0 || shift_cnt !== '0 || zero_flag !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset got=%h/%0d/%b exp=0/0/0", data_out, shift_cnt, zero_flag);
        end
        rst_n = 1'b1;

        // R3 R4: normalise corners
        run(1'b1, 16'h0001, '0, "R4 single low bit");
        run(1'b1, 16'h8000, '0, "R3 top bit already set");
        run(1'b1, 16'hFFFF, '0, "R3 all ones");
        run(1'b1, 16'h00A5, '0, "R4 eight leading zeros");
        // R5: zero word
        run(1'b1, 16'h0000, '0, "R5 zero input");
        // R9: ctrl ignored in normalise mode
        run(1'b1, 16'h0123, '1, "R9 ctrl all ones");
        run(1'b1, 16'h0123, 32'h5555_5555, "R9 ctrl all left codes");
        // R6 R7: explicit corners
        run(1'b0, 16'hBEEF, '0, "R6 all pass");
        run(1'b0, 16'hBEEF, '1, "R6 spare code passes");
        run(1'b0, 16'hFFFF, 32'h5555_5555, "R7 all left R8 zero");
        run(1'b0, 16'hFFFF, 32'hAAAA_AAAA, "R7 all right R8 zero");
        run(1'b0, 16'h0F0F, 32'h0000_0006, "R6 right then left order");
        run(1'b0, 16'h8001, 32'h0000_0009, "R6 left then right order");

        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] d;
            d = W'($urandom) >> $urandom_range(W, 0);
            run(1'b1, d, {$urandom, $urandom} , "R3 R4 R9 random normalise");
        end
        for (int i = 0; i < 400; i++) begin
            run(1'b0, W'($urandom), {$urandom, $urandom}, "R6 R7 R8 random explicit");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule